// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Control

This block sits beside a DDR SDRAM command controller and decides when an auto-refresh must happen. A free-running interval timer adds one owed refresh every `REFI_CYC` clock cycles. While anything is owed, the block raises a refresh request and holds it until the controller grants it. Each granted refresh removes one owed refresh. The block then keeps a command-block output high for the refresh cycle time, `RFC_CYC` cycles, so the controller sends nothing else to the memory in that window. If the controller falls behind, the owed count grows and an error flag rises once more than `MAX_OWED` are outstanding.

The block also runs self-refresh entry and exit. A self-refresh request first forces one extra refresh, even when nothing is owed. Entry then waits until that refresh and every owed one have been granted, the refresh cycle time has elapsed and the controller reports all banks idle. In that cycle the block issues a self-refresh command with CKE low. CKE stays low until an exit request arrives. On exit, CKE rises and the first cycle is held as a no-operation cycle. A forced refresh is requested from the next cycle on, and the interval timer restarts from the exit edge.

The timing parameters are given in clock cycles. By default they are derived from the clock frequency: a 7.8 µs interval (8192 refreshes per 64 ms) and a 75 ns refresh cycle.

Top module: `refresh_sched`

## Requirements
- R1: After reset, ref_req, sr_cmd, cmd_block and err are 0, cke is 1 and debt is 0.
- R2: Outside self refresh, debt rises by one at every REFI_CYC-th rising edge counted from reset release. ref_req is 1 while debt is nonzero, no refresh cycle is running and the block is not in self refresh.
- R3: Once raised, ref_req stays high until the rising edge at which ref_gnt is 1. A ref_gnt while ref_req is 0 has no effect on debt or cmd_block.
- R4: A granted refresh lowers debt by one; when an interval tick falls on the same edge, debt is unchanged. cmd_block is high for exactly RFC_CYC cycles, starting in the cycle after the grant, and ref_req is 0 in that time.
- R5: err is 1 exactly when debt exceeds MAX_OWED. debt saturates at 2*MAX_OWED.
- R6: sr_req in normal operation forces one extra refresh request even when debt is 0. Self-refresh entry waits until that refresh and all owed refreshes are granted, cmd_block is low and all_idle is 1.
- R7: In the entry cycle, sr_cmd is 1 for exactly one cycle and cke is 0 in that same cycle. cke stays 0 until sr_exit is seen.
- R8: During self refresh, ref_req is 0, debt is 0 and no interval ticks accumulate.
- R9: After the edge at which sr_exit is taken, cke is 1. In the first cycle after that edge, cmd_block is 1 and ref_req is 0. From the next cycle a forced refresh is requested. The next debt increment comes REFI_CYC edges after the exit edge.
- R10: sr_req is ignored outside normal operation, and sr_exit is ignored outside self refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| all_idle | input | 1 | Controller reports every bank precharged and idle |
| sr_req | input | 1 | Request to enter self refresh |
| sr_exit | input | 1 | Request to leave self refresh |
| ref_gnt | input | 1 | Controller grants the pending refresh this cycle |
| ref_req | output | 1 | Auto-refresh command requested |
| sr_cmd | output | 1 | Issue the self-refresh command this cycle |
| cke | output | 1 | Clock-enable level for the memory |
| cmd_block | output | 1 | No other command may be issued this cycle |
| debt | output | $clog2(2*MAX_OWED+1) (5) | Number of refreshes currently owed |
| err | output | 1 | More than MAX_OWED refreshes owed |

## Verification
The hardest case to reach is self-refresh entry held back by several owed refreshes. To set it up, the bench withholds grants for two whole intervals and only then raises sr_req with all banks idle. It grants the forced refresh and both owed ones one at a time, and checks that sr_cmd stays low until the last refresh cycle has ended. The case where a grant and an interval tick land on the same edge is reached by timing a grant to a multiple of the interval after reset. The saturation and error thresholds are reached by a sweep that withholds grants for eighteen intervals and checks debt and err after each one.

// File: rtl/rsch_pkg.sv
package rsch_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SELF  = 2'd2,
    ST_WAKE  = 2'd3
  } rsch_state_e;

  function automatic int cyc_floor(input int ns, input int mhz);
    return (ns * mhz) / 1000;
  endfunction

  function automatic int cyc_ceil(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int debt_cap(input int max_owed);
    return 2 * max_owed;
  endfunction

  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Owed-refresh arithmetic: a tick adds one, a grant removes one, both cancel.
  function automatic int debt_step(input int cur, input bit inc, input bit dec, input int cap);
    int n;
    n = cur;
    if (inc && !dec && n < cap) n = n + 1;
    else if (dec && !inc && n > 0) n = n - 1;
    return n;
  endfunction

endpackage

// File: rtl/rsch_interval.sv
module rsch_interval #(
  parameter int PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = rsch_pkg::cnt_w(PERIOD);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  generate
    if (PERIOD > 1) begin : g_spacing
      // R2: ticks never come on consecutive edges
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/rsch_debt.sv
module rsch_debt #(
  parameter int MAX_OWED = 8,
  parameter int W        = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] debt,
  output logic         err
);
  localparam int CAP = rsch_pkg::debt_cap(MAX_OWED);

  logic [W-1:0] debt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     debt_q <= '0;
    else if (clear) debt_q <= '0;
    else            debt_q <= W'(rsch_pkg::debt_step(int'(debt_q), inc, dec, CAP));
  end

  assign debt = debt_q;
  assign err  = int'(debt_q) > MAX_OWED;

  // R5: one more owed refresh past the limit raises the flag
  a_r5_err_on_overdue: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && inc && !dec && int'(debt) == MAX_OWED) |=> err);
  // R4: the scheduler only retires a refresh that is actually owed
  a_r4_dec_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (debt != '0));

endmodule

// File: rtl/rsch_rfc.sv
module rsch_rfc #(
  parameter int RFC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = rsch_pkg::cnt_w(RFC + 1);
  localparam logic [CW-1:0] LOAD = CW'(RFC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R4: a new refresh never starts inside the previous refresh cycle
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CLK_MHZ  = 200,
  parameter int REFI_CYC = rsch_pkg::cyc_floor(7800, CLK_MHZ),
  parameter int RFC_CYC  = rsch_pkg::cyc_ceil(75, CLK_MHZ),
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic all_idle,
  input  logic sr_req,
  input  logic sr_exit,
  input  logic ref_gnt,
  output logic ref_req,
  output logic sr_cmd,
  output logic cke,
  output logic cmd_block,
  output logic [rsch_pkg::cnt_w(rsch_pkg::debt_cap(MAX_OWED) + 1)-1:0] debt,
  output logic err
);
  import rsch_pkg::*;

  localparam int DW = cnt_w(debt_cap(MAX_OWED) + 1);

  rsch_state_e state_q, state_d;
  logic force_q, force_d;
  logic nop_q;

  // named internal events
  logic tick, grant, rfc_busy, enter_ok, take_sr, take_exit, dec, clr;
  logic [DW-1:0] debt_w;

  rsch_interval #(.PERIOD(REFI_CYC)) u_interval (
    .clk(clk), .rst_n(rst_n), .run(state_q != ST_SELF), .tick(tick)
  );

  rsch_debt #(.MAX_OWED(MAX_OWED), .W(DW)) u_debt (
    .clk(clk), .rst_n(rst_n), .clear(clr), .inc(tick), .dec(dec),
    .debt(debt_w), .err(err)
  );

  rsch_rfc #(.RFC(RFC_CYC)) u_rfc (
    .clk(clk), .rst_n(rst_n), .start(grant), .busy(rfc_busy)
  );

  assign ref_req   = (force_q || debt_w != '0) && !rfc_busy && !nop_q &&
                     (state_q != ST_SELF);
  assign grant     = ref_req && ref_gnt;
  assign dec       = grant && !force_q;
  assign enter_ok  = (state_q == ST_DRAIN) && !force_q && (debt_w == '0) &&
                     !rfc_busy && all_idle;
  assign take_sr   = (state_q == ST_RUN) && sr_req;
  assign take_exit = (state_q == ST_SELF) && sr_exit;
  assign clr       = enter_ok || (state_q == ST_SELF);

  assign sr_cmd    = enter_ok;
  assign cke       = !(enter_ok || state_q == ST_SELF);
  assign cmd_block = rfc_busy || nop_q;
  assign debt      = debt_w;

  always_comb begin
    state_d = state_q;
    force_d = force_q;
    if (grant && force_q) force_d = 1'b0;
    unique case (state_q)
      ST_RUN:   if (take_sr) begin state_d = ST_DRAIN; force_d = 1'b1; end
      ST_DRAIN: if (enter_ok) state_d = ST_SELF;
      ST_SELF:  if (take_exit) begin state_d = ST_WAKE; force_d = 1'b1; end
      ST_WAKE:  if (grant && force_q) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      force_q <= 1'b0;
      nop_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      force_q <= force_d;
      nop_q   <= take_exit;
    end
  end

  // R3: a raised request waits for its grant
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);
  // R4: a grant opens the refresh-cycle window
  a_r4_block_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (cmd_block && !ref_req));
  // R6: accepted self-refresh request yields a refresh request or an ongoing refresh
  a_r6_forced_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    take_sr |=> (ref_req || cmd_block));
  // R7: command only with banks idle and CKE low
  a_r7_cke_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    sr_cmd |-> (!cke && all_idle));
  // R7: CKE stays low until an exit request
  a_r7_cke_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !sr_exit) |=> !cke);
  // R8: no refresh requests while the memory refreshes itself
  a_r8_quiet_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!ref_req && debt == '0));
  // R9: exit gives one blocked no-operation cycle with CKE high
  a_r9_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
    take_exit |=> (cke && cmd_block && !ref_req));

endmodule

// File: tb/refresh_sched_tb.sv
`timescale 1ns/100ps
module refresh_sched_tb;
  localparam int REFI = 16;
  localparam int RFC  = 3;
  localparam int MAXO = 8;
  localparam int CAP  = 2 * MAXO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic all_idle = 1'b0, sr_req = 1'b0, sr_exit = 1'b0, ref_gnt = 1'b0;
  logic ref_req, sr_cmd, cke, cmd_block, err;
  logic [4:0] debt;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  refresh_sched #(.REFI_CYC(REFI), .RFC_CYC(RFC), .MAX_OWED(MAXO)) u_dut (
    .clk(clk), .rst_n(rst_n), .all_idle(all_idle), .sr_req(sr_req),
    .sr_exit(sr_exit), .ref_gnt(ref_gnt), .ref_req(ref_req), .sr_cmd(sr_cmd),
    .cke(cke), .cmd_block(cmd_block), .debt(debt), .err(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; all_idle = 1'b0; sr_req = 1'b0; sr_exit = 1'b0; ref_gnt = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic grant_one();
    ref_gnt = 1'b1; step(1); ref_gnt = 1'b0;
  endtask

  task automatic wait_req(output int spent);
    spent = 0;
    while (!ref_req && spent < 50) begin step(1); spent++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w;
    // ---- reset state and interval sweep
    do_reset();
    chk("R1 ref_req", int'(ref_req), 0);
    chk("R1 cke", int'(cke), 1);
    chk("R1 sr_cmd", int'(sr_cmd), 0);
    chk("R1 cmd_block", int'(cmd_block), 0);
    chk("R1 debt", int'(debt), 0);
    chk("R1 err", int'(err), 0);
    step(REFI - 1);
    chk("R2 debt before first tick", int'(debt), 0);
    chk("R2 no req before tick", int'(ref_req), 0);
    step(1);
    for (int k = 1; k <= 18; k++) begin
      int e;
      e = (k < CAP) ? k : CAP;
      chk("R2 debt per interval", int'(debt), e);
      chk("R2 req while owed", int'(ref_req), 1);
      chk("R5 err threshold", int'(err), (e > MAXO) ? 1 : 0);
      step(REFI);
    end

    // ---- grants
    do_reset();
    ref_gnt = 1'b1; step(1); ref_gnt = 1'b0;           // edge 1, nothing requested
    chk("R3 stray grant block", int'(cmd_block), 0);
    chk("R3 stray grant debt", int'(debt), 0);
    step(REFI - 1);                                     // edge 16
    chk("R2 first debt", int'(debt), 1);
    step(3);                                            // edge 19
    chk("R3 req held", int'(ref_req), 1);
    grant_one();                                        // edge 20
    chk("R4 debt after grant", int'(debt), 0);
    chk("R4 req low in rfc", int'(ref_req), 0);
    for (int i = 0; i < RFC; i++) begin
      chk("R4 block window", int'(cmd_block), 1);
      step(1);
    end
    chk("R4 block ends", int'(cmd_block), 0);

    do_reset();
    step(2 * REFI);                                     // edge 32, debt 2
    grant_one();                                        // edge 33
    chk("R4 debt two to one", int'(debt), 1);
    step(3 * REFI - 1 - 33);                            // edge 47
    ref_gnt = 1'b1; step(1); ref_gnt = 1'b0;            // edge 48 with tick
    chk("R4 tick plus grant", int'(debt), 1);

    // ---- self refresh entry and exit
    do_reset();
    sr_exit = 1'b1; step(1); sr_exit = 1'b0;            // edge 1 ignored
    chk("R10 exit ignored cke", int'(cke), 1);
    chk("R10 exit ignored block", int'(cmd_block), 0);
    sr_req = 1'b1; step(1); sr_req = 1'b0;              // edge 2
    chk("R6 forced req", int'(ref_req), 1);
    chk("R6 forced debt", int'(debt), 0);
    grant_one();                                        // edge 3
    chk("R6 forced refresh block", int'(cmd_block), 1);
    step(5);                                            // edge 8
    chk("R6 wait idle cmd", int'(sr_cmd), 0);
    chk("R6 wait idle cke", int'(cke), 1);
    all_idle = 1'b1; #1;
    chk("R7 cmd on entry", int'(sr_cmd), 1);
    chk("R7 cke with cmd", int'(cke), 0);
    step(1);                                            // edge 9
    chk("R7 cmd single", int'(sr_cmd), 0);
    chk("R7 cke held", int'(cke), 0);
    sr_req = 1'b1; step(1); sr_req = 1'b0;
    chk("R10 sr_req ignored in sr", int'(cke), 0);
    step(40);
    chk("R8 no req", int'(ref_req), 0);
    chk("R8 no debt", int'(debt), 0);
    chk("R7 cke still low", int'(cke), 0);
    sr_exit = 1'b1; step(1); sr_exit = 1'b0;            // exit edge X
    chk("R9 cke high", int'(cke), 1);
    chk("R9 nop block", int'(cmd_block), 1);
    chk("R9 nop no req", int'(ref_req), 0);
    step(1);                                            // X+1
    chk("R9 forced req", int'(ref_req), 1);
    chk("R9 block cleared", int'(cmd_block), 0);
    grant_one();                                        // X+2
    chk("R9 forced consumes nothing owed", int'(debt), 0);
    step(REFI - 3);                                     // X+15
    chk("R9 no tick yet", int'(debt), 0);
    step(1);                                            // X+16
    chk("R9 tick after exit", int'(debt), 1);

    // ---- entry held back by owed refreshes
    do_reset();
    step(2 * REFI);                                     // debt 2
    all_idle = 1'b1; sr_req = 1'b1; step(1); sr_req = 1'b0;
    for (int g = 0; g < 3; g++) begin
      wait_req(w);
      chk("R6 entry held while owed", int'(sr_cmd), 0);
      grant_one();
    end
    chk("R6 all owed retired", int'(debt), 0);
    chk("R6 held during rfc", int'(sr_cmd), 0);
    w = 0;
    while (cmd_block && w < 20) begin step(1); w++; end
    chk("R6 entry after drain", int'(sr_cmd), 1);
    chk("R7 cke low at entry", int'(cke), 0);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule